// File: doc/BRIEF.md
# Programmable Up-Counter Timer with Cascaded Prescalers

This block is a free-running up-counter that software reaches through a small memory-mapped register window. The window has an address, a write strobe, write data and combinational read data. Two tick-enable inputs stand in for two clock sources: a peripheral clock and a crystal reference. Each is a single-cycle pulse in the block's own clock domain.

Software writes a control word to enable counting and choose the tick source. It writes a prescale word that holds two divider values. When the crystal reference is chosen, its ticks pass first through a 4-bit reference divider and then through a 12-bit main divider, so the two divisions multiply. When the peripheral clock is chosen, only the main divider applies.

Software polls the count register to measure time. A self-clearing software reset bit returns the counter, both divider phases and the control fields to zero over a fixed number of cycles. Compare, capture and interrupt registers keep their slots in the window, but they read as zero.

Top module: `tick_timer`

## Requirements
- R1: After rst_n is released, the control word (byte offset 0x00), the prescale word (0x04) and the count (0x24) all read 0.
- R2: The control word keeps only these fields: bit 0 enable, bits 8:6 source code, bit 9 free-run, bit 10 reference enable, and bit 15 soft reset. The prescale word keeps only the main divider in bits 11:0 and the reference divider in bits 15:12. All other bits read 0; for example, writing 0xFFFF7FFF to control reads back 0x000007C1.
- R3: Offsets 0x08 through 0x20 read 0, and a write to them has no effect. A write to the count offset 0x24 does not change the count.
- R4: With source code 1, the count rises by one for every main+1 peripheral ticks. The reference ticks and the reference divider value have no effect.
- R5: With source code 5 and reference enable set, the count rises by one for every (ref+1)*(main+1) reference ticks.
- R6: Any source code other than 1 or 5, or code 5 with reference enable clear, leaves the count unchanged.
- R7: While the enable bit is 0, the count holds its value whatever ticks arrive.
- R8: A control write that changes enable from 0 to 1 clears the count and both divider phases. The first increment then comes after exactly one full division period.
- R9: A control write with bit 15 set starts a soft reset. Bit 15 then reads 1 for SRST_CYCLES cycles (4 by default) and then 0. The reset clears the count, both divider phases and every other control field. The prescale word keeps its value, and control writes made during the reset are dropped.
- R10: The count wraps from all ones to 0 on the next increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| periph_tick | input | 1 | One-cycle tick from the peripheral clock |
| ref_tick | input | 1 | One-cycle tick from the crystal reference |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
The assertions take for granted that every tick input is a pulse sampled once per clock. They also assume that each bus write lasts exactly one cycle, so a rising enable or a soft-reset request is seen at one edge only. The stimulus raises the write strobe for a single cycle and drives every tick as a one-cycle pulse followed by an idle cycle. Both ticks are pulsed together, so the unselected source is always active and its being ignored is actually tested. A second, narrow-counter instance shares the same stimulus, which lets the wrap be reached in a few hundred ticks.

// File: rtl/tt_pkg.sv
package tt_pkg;
  localparam int BUS_W  = 32;
  localparam int MAIN_W = 12;
  localparam int REF_W  = 4;
  localparam int SRC_W  = 3;

  // field positions that software decodes
  localparam int CTRL_EN    = 0;
  localparam int CTRL_SRC   = 6;
  localparam int CTRL_FREE  = 9;
  localparam int CTRL_REFEN = 10;
  localparam int CTRL_SRST  = 15;
  localparam int PRE_MAIN   = 0;
  localparam int PRE_REF    = 12;

  // word indices in the window
  localparam int IDX_CTRL  = 0;
  localparam int IDX_PRE   = 1;
  localparam int IDX_COUNT = 9;

  localparam logic [SRC_W-1:0] SRC_PERIPH = 3'd1;
  localparam logic [SRC_W-1:0] SRC_REF    = 3'd5;

  // a divider stage emits when its phase has reached the programmed value
  function automatic logic div_hit(input logic [MAIN_W-1:0] phase,
                                   input logic [MAIN_W-1:0] lim);
    return phase >= lim;
  endfunction
endpackage

// File: rtl/tt_regs.sv
module tt_regs import tt_pkg::*; #(
  parameter int ADDR_W      = 6,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [BUS_W-1:0]  wdata,
  output logic              en,
  output logic [SRC_W-1:0]  src,
  output logic              ref_en,
  output logic [MAIN_W-1:0] main_div,
  output logic [REF_W-1:0]  ref_div,
  output logic              srst_busy,
  output logic              clr,
  output logic [BUS_W-1:0]  ctrl_rd,
  output logic [BUS_W-1:0]  pre_rd
);
  localparam int SRST_W = $clog2(SRST_CYCLES + 1);

  logic [SRST_W-1:0] busy_cnt;
  logic              free_run;
  logic              wr_ctrl, wr_pre, srst_req, start_req;
  logic [ADDR_W-3:0] word;

  assign word      = addr[ADDR_W-1:2];
  assign wr_ctrl   = we && (word == (ADDR_W-2)'(IDX_CTRL)) && !srst_busy;
  assign wr_pre    = we && (word == (ADDR_W-2)'(IDX_PRE));
  assign srst_req  = wr_ctrl && wdata[CTRL_SRST];
  assign start_req = wr_ctrl && !wdata[CTRL_SRST] && wdata[CTRL_EN] && !en;
  assign clr       = srst_req || start_req;
  assign srst_busy = (busy_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
      en       <= 1'b0;
      src      <= '0;
      free_run <= 1'b0;
      ref_en   <= 1'b0;
      main_div <= '0;
      ref_div  <= '0;
    end else begin
      if (srst_busy) busy_cnt <= busy_cnt - SRST_W'(1);
      if (srst_req) begin
        busy_cnt <= SRST_W'(SRST_CYCLES);
        en       <= 1'b0;
        src      <= '0;
        free_run <= 1'b0;
        ref_en   <= 1'b0;
      end else if (wr_ctrl) begin
        en       <= wdata[CTRL_EN];
        src      <= wdata[CTRL_SRC +: SRC_W];
        free_run <= wdata[CTRL_FREE];
        ref_en   <= wdata[CTRL_REFEN];
      end
      if (wr_pre) begin
        main_div <= wdata[PRE_MAIN +: MAIN_W];
        ref_div  <= wdata[PRE_REF +: REF_W];
      end
    end
  end

  always_comb begin
    ctrl_rd                    = '0;
    ctrl_rd[CTRL_EN]           = en;
    ctrl_rd[CTRL_SRC +: SRC_W] = src;
    ctrl_rd[CTRL_FREE]         = free_run;
    ctrl_rd[CTRL_REFEN]        = ref_en;
    ctrl_rd[CTRL_SRST]         = srst_busy;
    pre_rd                     = '0;
    pre_rd[PRE_MAIN +: MAIN_W] = main_div;
    pre_rd[PRE_REF +: REF_W]   = ref_div;
  end

  // R9: the cycle the reset starts, every control field is already zero
  assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(srst_busy) |-> (!en && src == '0 && !ref_en && !free_run));
  // R9: counting cannot be enabled while the reset is in progress
  assert_srst_no_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> !en);
endmodule

// File: rtl/tt_div.sv
module tt_div import tt_pkg::*; #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         tick_in,
  input  logic [W-1:0] lim,
  output logic         tick_out
);
  logic [W-1:0] phase;
  logic         hit;

  assign hit      = div_hit(MAIN_W'(phase), MAIN_W'(lim));
  assign tick_out = tick_in && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clr)     phase <= '0;
    else if (tick_in) phase <= hit ? '0 : phase + W'(1);
  end

  // R8: right after a clear, a divider passes a tick only when it divides by one
  assert_div_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (tick_out -> lim == '0));
endmodule

// File: rtl/tt_prescale.sv
module tt_prescale import tt_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [SRC_W-1:0]  src,
  input  logic              ref_en,
  input  logic              periph_tick,
  input  logic              ref_tick,
  input  logic [REF_W-1:0]  ref_div,
  input  logic [MAIN_W-1:0] main_div,
  output logic              cnt_tick
);
  logic ref_in, ref_out, main_in;

  assign ref_in  = en && ref_en && (src == SRC_REF) && ref_tick;
  assign main_in = en && ((src == SRC_PERIPH) ? periph_tick : ref_out);

  tt_div #(.W(REF_W)) u_ref_div (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .tick_in(ref_in), .lim(ref_div), .tick_out(ref_out)
  );

  tt_div #(.W(MAIN_W)) u_main_div (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .tick_in(main_in), .lim(main_div), .tick_out(cnt_tick)
  );

  // R6: a count tick requires an enabled, valid source
  assert_src_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |-> (en && (src == SRC_PERIPH || (src == SRC_REF && ref_en))));
  // R4: on the peripheral source, every count tick coincides with a peripheral tick
  assert_periph_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && src == SRC_PERIPH) |-> periph_tick);
  // R5: on the reference source, every count tick coincides with a reference tick
  assert_ref_chain_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && src == SRC_REF) |-> ref_tick);
endmodule

// File: rtl/tt_count.sv
module tt_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + CNT_W'(1);
  end

  // R7: without an increment or a clear the count holds
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(count));
  // R10: an increment from all ones lands on zero
  assert_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && count == '1) |=> count == '0);
  // R8: a clear always leaves the count at zero
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> count == '0);
endmodule

// File: rtl/tick_timer.sv
module tick_timer import tt_pkg::*; #(
  parameter int ADDR_W      = 6,
  parameter int CNT_W       = 32,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              periph_tick,
  input  logic              ref_tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic              en, ref_en, srst_busy, clr, cnt_tick;
  logic [SRC_W-1:0]  src;
  logic [MAIN_W-1:0] main_div;
  logic [REF_W-1:0]  ref_div;
  logic [BUS_W-1:0]  ctrl_rd, pre_rd;
  logic [CNT_W-1:0]  count;
  logic [ADDR_W-3:0] word;

  tt_regs #(.ADDR_W(ADDR_W), .SRST_CYCLES(SRST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .en(en), .src(src), .ref_en(ref_en), .main_div(main_div), .ref_div(ref_div),
    .srst_busy(srst_busy), .clr(clr), .ctrl_rd(ctrl_rd), .pre_rd(pre_rd)
  );

  tt_prescale u_prescale (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .src(src), .ref_en(ref_en),
    .periph_tick(periph_tick), .ref_tick(ref_tick), .ref_div(ref_div),
    .main_div(main_div), .cnt_tick(cnt_tick)
  );

  tt_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(cnt_tick), .count(count)
  );

  assign word = bus_addr[ADDR_W-1:2];

  always_comb begin
    bus_rdata = '0;
    if (word == (ADDR_W-2)'(IDX_CTRL))       bus_rdata = ctrl_rd;
    else if (word == (ADDR_W-2)'(IDX_PRE))   bus_rdata = pre_rd;
    else if (word == (ADDR_W-2)'(IDX_COUNT)) bus_rdata = BUS_W'(count);
  end

  // R3: the reserved slots never return data
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (word > (ADDR_W-2)'(IDX_PRE) && word < (ADDR_W-2)'(IDX_COUNT)) |-> bus_rdata == '0);
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        periph_tick = 1'b0;
  logic        ref_tick = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata, rdata_w8;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tick_timer u_tick_timer (
    .clk(clk), .rst_n(rst_n), .periph_tick(periph_tick), .ref_tick(ref_tick),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  tick_timer #(.CNT_W(8)) u_tick_timer_w8 (
    .clk(clk), .rst_n(rst_n), .periph_tick(periph_tick), .ref_tick(ref_tick),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(rdata_w8)
  );

  // vector table: source, ref enable, ref divider, main divider, ticks, expected count
  localparam int NV = 8;
  localparam int V_SRC [NV] = '{1, 1, 1, 5, 5, 5, 5, 2};
  localparam int V_RE  [NV] = '{0, 0, 1, 1, 1, 1, 0, 1};
  localparam int V_RD  [NV] = '{0, 0, 3, 0, 3, 15, 0, 0};
  localparam int V_MD  [NV] = '{0, 2, 0, 0, 1, 0, 0, 0};
  localparam int V_N   [NV] = '{10, 10, 6, 7, 20, 40, 5, 5};
  localparam int V_EXP [NV] = '{10, 3, 6, 7, 2, 2, 0, 0};
  localparam int V_REQ [NV] = '{4, 4, 4, 5, 5, 5, 6, 6}; // R4 R5 R6

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      periph_tick = 1'b1; ref_tick = 1'b1;
      @(negedge clk);
      periph_tick = 1'b0; ref_tick = 1'b0;
    end
  endtask

  function automatic logic [31:0] ctrl_word(input int s, input int re, input int e);
    return 32'(e) | (32'(s) << 6) | (32'd1 << 9) | (32'(re) << 10);
  endfunction

  task automatic restart(input int s, input int re);
    wr(6'h00, ctrl_word(s, re, 0));
    wr(6'h00, ctrl_word(s, re, 1));
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values
    rd(6'h00, v); check("R1 ctrl", v, 32'h0);
    rd(6'h04, v); check("R1 prescale", v, 32'h0);
    rd(6'h24, v); check("R1 count", v, 32'h0);

    // R2: field masks
    wr(6'h00, 32'hFFFF_7FFF);
    rd(6'h00, v); check("R2 ctrl mask", v, 32'h0000_07C1);
    wr(6'h00, 32'h0);
    wr(6'h04, 32'hFFFF_FFFF);
    rd(6'h04, v); check("R2 prescale mask", v, 32'h0000_FFFF);

    // R3: reserved offsets and count write
    for (int a = 8; a <= 32; a += 4) begin
      wr(6'(a), 32'hFFFF_FFFF);
      rd(6'(a), v); check($sformatf("R3 offset 0x%02h", a), v, 32'h0);
    end
    wr(6'h24, 32'h1234_5678);
    rd(6'h24, v); check("R3 count write", v, 32'h0);
    rd(6'h04, v); check("R3 prescale kept", v, 32'h0000_FFFF);
    rd(6'h00, v); check("R3 ctrl kept", v, 32'h0);

    // R4 R5 R6: vector table
    for (int i = 0; i < NV; i++) begin
      wr(6'h04, (32'(V_RD[i]) << 12) | 32'(V_MD[i]));
      restart(V_SRC[i], V_RE[i]);
      pulse(V_N[i]);
      rd(6'h24, v); check($sformatf("R%0d vector %0d", V_REQ[i], i), v, 32'(V_EXP[i]));
    end

    // R7: disabled counter holds
    wr(6'h04, 32'h0);
    restart(1, 0);
    pulse(3);
    rd(6'h24, v); check("R7 before disable", v, 32'd3);
    wr(6'h00, ctrl_word(1, 0, 0));
    pulse(4);
    rd(6'h24, v); check("R7 held while disabled", v, 32'd3);

    // R8: enable rise clears count and phase
    wr(6'h04, 32'd2);
    wr(6'h00, ctrl_word(1, 0, 1));
    rd(6'h24, v); check("R8 cleared on enable", v, 32'd0);
    pulse(2);
    wr(6'h00, ctrl_word(1, 0, 0));
    wr(6'h00, ctrl_word(1, 0, 1));
    pulse(2);
    rd(6'h24, v); check("R8 phase cleared", v, 32'd0);
    pulse(1);
    rd(6'h24, v); check("R8 first full period", v, 32'd1);

    // R9: soft reset
    wr(6'h04, 32'h0000_5005);
    wr(6'h00, 32'h0000_8000);
    for (int i = 0; i < 4; i++) begin
      rd(6'h00, v); check($sformatf("R9 busy cycle %0d", i), v, 32'h0000_8000);
      if (i == 1) begin
        bus_addr = 6'h00; bus_wdata = ctrl_word(1, 0, 1); bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    rd(6'h00, v); check("R9 bit clears", v, 32'h0);
    rd(6'h24, v); check("R9 count cleared", v, 32'h0);
    rd(6'h04, v); check("R9 prescale kept", v, 32'h0000_5005);
    pulse(2);
    rd(6'h24, v); check("R9 write in reset dropped", v, 32'h0);

    // R10: wrap on the narrow instance
    wr(6'h04, 32'h0);
    restart(1, 0);
    pulse(258);
    rd(6'h24, v); check("R10 wide count", v, 32'd258);
    check("R10 narrow wrapped", rdata_w8, 32'd2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule